// File: doc/BRIEF.md
# Constant-Weight Spike Event Codec

This block carries spike events for a population of 32 neurons over a narrow shared bus without arbitration. Every neuron owns a 7-bit address holding exactly three ones. On the transmit side, each cycle the block takes the set of neurons that fired and places the bitwise OR of their addresses on the bus. When several neurons fire together, their codes therefore merge into one word, and the bus carries no separate record of who sent what. A polarity bit travels with the word and marks the event as excitatory or inhibitory.

On the receive side, each valid bus word is decoded into a per-neuron stimulus pulse. The pulse goes to the excitatory or the inhibitory output vector according to the polarity bit. A received word that holds more than three ones shows that senders overlapped. A mode input then picks one of two handling policies. The first discards the event. The second stimulates every neuron whose code fits entirely inside the received ones, which means every neuron that could have been among the senders. Words with fewer than three ones are treated as noise and are ignored.

The two halves are independent, so the transmit side of one chip can feed the receive side of another, with any OR-merging of several chips done on the wires in between.

Top module: `aer_cw_codec`

## Requirements
- R1: The address of neuron i is the i-th 7-bit value, counting from zero in ascending numeric order, that holds exactly three ones. Neuron 0 is 7'b0000111, neuron 1 is 7'b0001011, and neuron 31 is the 32nd such value. Every transmitted valid word holds at least three ones.
- R2: One cycle after exactly one bit of `spike_in` is high, `tx_word` equals that neuron's address and `tx_valid` is 1.
- R3: One cycle after any set of spikes, `tx_word` is the bitwise OR of the addresses of all spiking neurons, and `tx_valid` is 1 exactly when at least one spike was present. With no spikes, `tx_word` is all zeros.
- R4: `tx_inhib` is `spike_inhib` delayed by one cycle while `tx_valid` is 1, and is 0 otherwise.
- R5: One cycle after a valid received word that equals the address of neuron i, exactly bit i of one stimulus vector is 1.
- R6: The stimulus goes to `stim_inh` when `rx_inhib` is 1 and to `stim_exc` when it is 0. The other vector stays all zeros, so both vectors are never high in the same bit position.
- R7: With `drop_on_collide` = 1, a valid received word holding more than three ones produces no stimulus.
- R8: With `drop_on_collide` = 0, a valid received word holding more than three ones sets stimulus bit i for every neuron i whose address ones all lie inside the received ones, and for no other neuron.
- R9: A valid received word holding fewer than three ones (all zeros included) produces no stimulus in either mode. A word holding three ones that is not one of the 32 assigned addresses also produces no stimulus.
- R10: While `rx_valid` is 0, both stimulus vectors are zero one cycle later. A stimulus pulse stays high for as many cycles as the same valid word is held.
- R11: While `rst` is 1, and in the first cycle after it, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spike_in | input | 32 | Neurons firing this cycle |
| spike_inhib | input | 1 | Polarity of this cycle's outgoing spikes (1 = inhibitory) |
| tx_word | output | 7 | Merged outgoing address word |
| tx_valid | output | 1 | Outgoing word carries an event |
| tx_inhib | output | 1 | Polarity of the outgoing event |
| rx_word | input | 7 | Incoming bus word |
| rx_valid | input | 1 | Incoming word carries an event |
| rx_inhib | input | 1 | Polarity of the incoming event |
| drop_on_collide | input | 1 | Collision policy: 1 discards the event, 0 fans it out |
| stim_exc | output | 32 | Excitatory stimulus per neuron |
| stim_inh | output | 32 | Inhibitory stimulus per neuron |

## Verification
Both halves register their outputs, so every result is due on the first rising edge after its inputs are applied. The bench changes inputs on a falling edge and reads the outputs on the next falling edge, which is exactly one register later. The receive side is swept over all 128 bus words, both collision policies and both polarities, and every expected vector is computed from subset arithmetic over the bench's own address list. Hold tests keep one word valid for several cycles and check the pulse on every one of those cycles. They then check that the pulse clears one cycle after the valid drops.

// File: rtl/aer_cw_pkg.sv
package aer_cw_pkg;
  // Returns the idx-th value (ascending, zero-based) of the given width
  // whose population count equals `ones`; zero if there are not enough.
  function automatic logic [15:0] nth_code(int idx, int width, int ones);
    int seen;
    logic [15:0] res;
    seen = 0;
    res  = '0;
    for (int v = 0; v < (1 << width); v++) begin
      if ($countones(16'(v)) == ones) begin
        if (seen == idx) res = 16'(v);
        seen++;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/aer_popcount.sv
module aer_popcount #(
  parameter int W  = 7,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits_in,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int b = 0; b < W; b++) count = count + CW'(bits_in[b]);
  end
endmodule

// File: rtl/aer_encoder.sv
module aer_encoder #(
  parameter int N      = 32,
  parameter int ADDR_W = 7,
  parameter int ONES   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      spike_in,
  input  logic              spike_inhib,
  output logic [ADDR_W-1:0] tx_word,
  output logic              tx_valid,
  output logic              tx_inhib
);
  // Per bus bit: the set of neurons whose address drives that bit.
  logic [N-1:0] bit_users [ADDR_W];

  for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
    for (genvar i = 0; i < N; i++) begin : g_nrn
      localparam logic [ADDR_W-1:0] CW = ADDR_W'(aer_cw_pkg::nth_code(i, ADDR_W, ONES));
      assign bit_users[b][i] = CW[b];
    end
  end

  logic [ADDR_W-1:0] word_nxt;
  logic              any_spike;

  always_comb begin
    for (int b = 0; b < ADDR_W; b++) word_nxt[b] = |(spike_in & bit_users[b]);
    any_spike = |spike_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_word  <= '0;
      tx_valid <= 1'b0;
      tx_inhib <= 1'b0;
    end else begin
      tx_word  <= word_nxt;
      tx_valid <= any_spike;
      tx_inhib <= any_spike & spike_inhib;
    end
  end

  // R1: any transmitted event carries at least the code weight
  p_tx_weight_r1: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> ($countones(tx_word) >= ONES));
  // R3: a spike on the inputs yields a valid word next cycle
  p_tx_valid_r3: assert property (@(posedge clk) disable iff (rst)
    (|spike_in) |=> tx_valid);
  // R3: an idle bus is all zeros
  p_tx_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !tx_valid |-> (tx_word == '0));
  // R4: polarity only accompanies a valid event
  p_tx_pol_r4: assert property (@(posedge clk) disable iff (rst)
    tx_inhib |-> tx_valid);
endmodule

// File: rtl/aer_decoder.sv
module aer_decoder #(
  parameter int N      = 32,
  parameter int ADDR_W = 7,
  parameter int ONES   = 3,
  localparam int WT_W  = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rx_word,
  input  logic              rx_valid,
  input  logic              rx_inhib,
  input  logic              drop_on_collide,
  output logic [N-1:0]      stim_exc,
  output logic [N-1:0]      stim_inh
);
  logic [WT_W-1:0] weight;
  logic [N-1:0]    covered;
  logic [N-1:0]    sel;

  aer_popcount #(.W(ADDR_W)) u_wt (
    .bits_in (rx_word),
    .count   (weight)
  );

  // A neuron is covered when every one of its address ones is present.
  for (genvar i = 0; i < N; i++) begin : g_cover
    localparam logic [ADDR_W-1:0] CW = ADDR_W'(aer_cw_pkg::nth_code(i, ADDR_W, ONES));
    assign covered[i] = ((CW & ~rx_word) == '0);
  end

  always_comb begin
    sel = '0;
    if (rx_valid) begin
      if (weight == WT_W'(ONES))
        sel = covered;               // exact match: at most one neuron
      else if (weight > WT_W'(ONES) && !drop_on_collide)
        sel = covered;               // fan out to possible senders
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stim_exc <= '0;
      stim_inh <= '0;
    end else begin
      stim_exc <= rx_inhib ? '0 : sel;
      stim_inh <= rx_inhib ? sel : '0;
    end
  end

  // R5: a clean word addresses at most one neuron
  p_onehot_exact_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && $countones(rx_word) == ONES) |=> $onehot0(stim_exc | stim_inh));
  // R6: the two polarity vectors never overlap
  p_no_overlap_r6: assert property (@(posedge clk) disable iff (rst)
    ((stim_exc & stim_inh) == '0));
  // R7: collisions are silent in drop mode
  p_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && drop_on_collide && $countones(rx_word) > ONES)
      |=> (stim_exc == '0 && stim_inh == '0));
  // R9: light words never stimulate
  p_light_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && $countones(rx_word) < ONES) |=> (stim_exc == '0 && stim_inh == '0));
  // R10: no valid, no stimulus
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> (stim_exc == '0 && stim_inh == '0));
endmodule

// File: rtl/aer_cw_codec.sv
module aer_cw_codec #(
  parameter int N      = 32,
  parameter int ADDR_W = 7,
  parameter int ONES   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      spike_in,
  input  logic              spike_inhib,
  output logic [ADDR_W-1:0] tx_word,
  output logic              tx_valid,
  output logic              tx_inhib,
  input  logic [ADDR_W-1:0] rx_word,
  input  logic              rx_valid,
  input  logic              rx_inhib,
  input  logic              drop_on_collide,
  output logic [N-1:0]      stim_exc,
  output logic [N-1:0]      stim_inh
);
  aer_encoder #(.N(N), .ADDR_W(ADDR_W), .ONES(ONES)) u_enc (
    .clk         (clk),
    .rst         (rst),
    .spike_in    (spike_in),
    .spike_inhib (spike_inhib),
    .tx_word     (tx_word),
    .tx_valid    (tx_valid),
    .tx_inhib    (tx_inhib)
  );

  aer_decoder #(.N(N), .ADDR_W(ADDR_W), .ONES(ONES)) u_dec (
    .clk             (clk),
    .rst             (rst),
    .rx_word         (rx_word),
    .rx_valid        (rx_valid),
    .rx_inhib        (rx_inhib),
    .drop_on_collide (drop_on_collide),
    .stim_exc        (stim_exc),
    .stim_inh        (stim_inh)
  );

  // R11: outputs are cleared in the cycle after reset
  p_reset_clear_r11: assert property (@(posedge clk)
    $past(rst) |-> (tx_word == '0 && !tx_valid && !tx_inhib &&
                    stim_exc == '0 && stim_inh == '0));
endmodule

// File: tb/aer_cw_codec_tb_top.sv
module aer_cw_codec_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] spike_in;
  logic        spike_inhib;
  logic [6:0]  tx_word;
  logic        tx_valid;
  logic        tx_inhib;
  logic [6:0]  rx_word;
  logic        rx_valid;
  logic        rx_inhib;
  logic        drop_on_collide;
  logic [31:0] stim_exc;
  logic [31:0] stim_inh;

  int checks   = 0;
  int failures = 0;
  logic [6:0] code_tab [32];

  always #10 clk = ~clk;   // 50 MHz

  aer_cw_codec dut_i (
    .clk, .rst, .spike_in, .spike_inhib, .tx_word, .tx_valid, .tx_inhib,
    .rx_word, .rx_valid, .rx_inhib, .drop_on_collide, .stim_exc, .stim_inh
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_stim(logic [6:0] w, logic drop);
    int wt = $countones(w);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) begin
      if (wt == 3) r[i] = (code_tab[i] == w);
      else if (wt > 3 && !drop) r[i] = ((code_tab[i] | w) == w);
    end
    return r;
  endfunction

  function automatic logic [6:0] exp_or(logic [31:0] s);
    logic [6:0] r = '0;
    for (int i = 0; i < 32; i++) if (s[i]) r = r | code_tab[i];
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] pat;
    int n;
    n = 0;
    for (int v = 0; v < 128; v++)
      if ($countones(v[6:0]) == 3 && n < 32) begin code_tab[n] = v[6:0]; n++; end

    rst = 1'b1; spike_in = '0; spike_inhib = 0;
    rx_word = '0; rx_valid = 0; rx_inhib = 0; drop_on_collide = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 tx", {tx_word, tx_valid, tx_inhib}, '0);
    chk("R11 stim", {stim_exc, stim_inh}, '0);
    rst = 1'b0;

    // R1 / R2: every single spiker, alternating polarity
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); spike_in = 32'b1 << i; spike_inhib = i[0];
      @(negedge clk);
      chk("R1 R2 single word", {57'd0, tx_word}, {57'd0, code_tab[i]});
      chk("R2 valid", {63'd0, tx_valid}, 64'd1);
      chk("R4 polarity", {63'd0, tx_inhib}, {63'd0, i[0]});
    end
    chk("R1 first code", {57'd0, code_tab[0]}, 64'h07);

    // R3: merged senders
    pat = 32'h1234_5679;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      pat = pat * 32'd1103515245 + 32'd12345;
      spike_in = (k % 3 == 0) ? (pat & (pat >> 7) & (pat >> 13)) : pat;
      spike_inhib = 1'b1;
      @(negedge clk);
      chk("R3 merged word", {57'd0, tx_word}, {57'd0, exp_or(spike_in)});
      chk("R3 valid", {63'd0, tx_valid}, {63'd0, |spike_in});
    end
    @(negedge clk); spike_in = '0; spike_inhib = 1'b1;
    @(negedge clk);
    chk("R3 idle", {tx_word, tx_valid}, '0);
    chk("R4 idle polarity", {63'd0, tx_inhib}, '0);

    // R5-R9: exhaustive receive sweep
    for (int m = 0; m < 4; m++) begin
      for (int w = 0; w < 128; w++) begin
        logic [31:0] e;
        @(negedge clk);
        rx_word = w[6:0]; rx_valid = 1'b1;
        drop_on_collide = m[0]; rx_inhib = m[1];
        e = exp_stim(w[6:0], m[0]);
        @(negedge clk);
        if (rx_inhib) chk("R5-9 sweep inh", {stim_exc, stim_inh}, {32'd0, e});
        else          chk("R5-9 sweep exc", {stim_exc, stim_inh}, {e, 32'd0});
      end
    end
    // R6 explicit: neuron 31, inhibitory
    @(negedge clk); rx_word = code_tab[31]; rx_inhib = 1; rx_valid = 1; drop_on_collide = 1;
    @(negedge clk);
    chk("R6 route", {stim_exc, stim_inh}, {32'd0, 32'h8000_0000});
    // R7 / R8 explicit: all-ones word
    @(negedge clk); rx_word = 7'h7f; rx_inhib = 0;
    @(negedge clk);
    chk("R7 drop", {stim_exc, stim_inh}, '0);
    @(negedge clk); drop_on_collide = 0;
    @(negedge clk);
    chk("R8 fanout", {stim_exc, stim_inh}, {32'hffff_ffff, 32'd0});
    // R9 zero word
    @(negedge clk); rx_word = '0;
    @(negedge clk);
    chk("R9 zero word", {stim_exc, stim_inh}, '0);

    // R10: hold for 3 cycles, then drop valid
    @(negedge clk); rx_word = code_tab[5]; rx_valid = 1; rx_inhib = 0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R10 hold", {32'd0, stim_exc}, 64'h20);
    end
    rx_valid = 0;
    @(negedge clk);
    chk("R10 release", {stim_exc, stim_inh}, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule